// File: doc/BRIEF.md
# DMA channel control, status and interrupt unit

This block holds the control and status word of every channel of a multi-channel DMA engine and folds the channels' interrupt causes into one interrupt line. Software writes a 32-bit word to one channel at a time. Some status flags are cleared by writing ones. The control fields are stored as written. A run write marks the channel as started and, unless descriptor fetch is suppressed, also asks for a descriptor fetch.

The channel engines report what they did through single-cycle event pulses: bus error, start, end, stopped, request-after-stop and end-of-receive. Each pulse sets the matching status flag. The block returns control levels to the engines: run, no-fetch, stop on end-of-receive, and jump on end-of-receive. It also returns one-cycle pulses for a channel start and a descriptor fetch.

Per-class pending bitmaps, a per-channel pending summary and a combined interrupt are built from the stored flags and enables. A read port returns the word of any channel. In that word, the live request level of the channel appears in bit 8.

Top module: `dma_csr_unit`

## Requirements
- R1: After reset, every channel reads 0x00000008: the stopped flag at bit 3 is set and every other bit is clear. All pending outputs, irq_o, control levels and pulses are low.
- R2: A write clears status bit 0 (bus error), bit 1 (start), bit 2 (end) and bit 9 (end-of-receive) wherever the written word has a one, and leaves them unchanged where it has a zero. Bit 4 (request-after-stop) is not changed by any write.
- R3: A write stores bits 31:26 and 23 exactly as written. Bit 22 and every other bit outside the status fields are not stored and read as 0.
- R4: A write with bit 31 (run) set clears the stopped flag. In the next cycle it pulses chan_start_o for that channel. It also pulses desc_fetch_o for that channel when bit 30 (no-fetch) of the written word is clear.
- R5: A write with both bit 31 and bit 22 (mask-run) clear sets the stopped flag. A write with bit 31 clear and bit 22 set leaves the stopped flag unchanged.
- R6: Write bit 24 clears the compare flag at bit 10 and write bit 25 sets it. When both bits are written as one, the flag ends up set.
- R7: Bit 8 of the read word equals req_lvl_i of the channel selected for reading, in the same cycle, without a register stage.
- R8: The pending classes of a channel are computed as follows. Stop is stopped AND bit 29. End-of-receive is bit 9 AND bit 28. Request-after-stop is bit 4 AND bit 23. Start is bit 1 and end is bit 2, with no enable.
- R9: pend_sum_o of a channel is the OR of its five pending classes. irq_o is high exactly when some bit of pend_sum_o is set.
- R10: When an event pulse and a one-to-clear write hit the same flag in the same cycle, the flag ends up set.
- R11: An event pulse sets its flag in the following cycle. The flag positions are: bus error at bit 0, start at 1, end at 2, stopped at 3, request-after-stop at 4 and end-of-receive at 9.
- R12: run_o, nofetch_o, eor_stop_o and eor_jump_o follow stored bits 31, 30, 26 and 27. They change only on a write to that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | CH_W | Channel addressed by the write |
| wr_data_i | input | 32 | Written word |
| rd_ch_i | input | CH_W | Channel selected for reading |
| rd_data_o | output | 32 | Word of the selected channel |
| req_lvl_i | input | NUM_CH | Live request level per channel |
| ev_buserr_i | input | NUM_CH | Bus error event pulse |
| ev_start_i | input | NUM_CH | Descriptor start event pulse |
| ev_end_i | input | NUM_CH | Transfer end event pulse |
| ev_stop_i | input | NUM_CH | Channel stopped event pulse |
| ev_ras_i | input | NUM_CH | Request-after-stop event pulse |
| ev_eor_i | input | NUM_CH | End-of-receive event pulse |
| run_o | output | NUM_CH | Run level per channel |
| nofetch_o | output | NUM_CH | No-descriptor-fetch level |
| eor_stop_o | output | NUM_CH | Stop on end-of-receive level |
| eor_jump_o | output | NUM_CH | Jump on end-of-receive level |
| chan_start_o | output | NUM_CH | One-cycle start pulse |
| desc_fetch_o | output | NUM_CH | One-cycle descriptor fetch pulse |
| pend_stop_o | output | NUM_CH | Pending stop class |
| pend_eor_o | output | NUM_CH | Pending end-of-receive class |
| pend_ras_o | output | NUM_CH | Pending request-after-stop class |
| pend_start_o | output | NUM_CH | Pending start class |
| pend_end_o | output | NUM_CH | Pending end class |
| pend_sum_o | output | NUM_CH | Per-channel OR of the classes |
| irq_o | output | 1 | Combined interrupt |

## Verification
The properties assume that wr_en_i and all event inputs are driven to 0 throughout reset. They also assume that a write addresses an existing channel whenever its effect on a channel output is checked. The bench meets both conditions: it holds every input at zero until reset is released, and it draws write channels only from the range of its four-channel build. It sweeps pseudo-random write words and sparse event patterns across all channels, so that writes and events often collide in the same cycle. Each result is compared against an arithmetic model of the write and event rules.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int unsigned WORD_W = 32;

  localparam int unsigned B_BUSERR  = 0;
  localparam int unsigned B_START   = 1;
  localparam int unsigned B_END     = 2;
  localparam int unsigned B_STOP    = 3;
  localparam int unsigned B_RAS     = 4;
  localparam int unsigned B_REQ     = 8;
  localparam int unsigned B_EOR     = 9;
  localparam int unsigned B_CMP     = 10;
  localparam int unsigned B_MRUN    = 22;
  localparam int unsigned B_RASIE   = 23;
  localparam int unsigned B_CMPCLR  = 24;
  localparam int unsigned B_CMPSET  = 25;
  localparam int unsigned B_EORSTOP = 26;
  localparam int unsigned B_EORJMP  = 27;
  localparam int unsigned B_EORIE   = 28;
  localparam int unsigned B_STOPIE  = 29;
  localparam int unsigned B_NOFETCH = 30;
  localparam int unsigned B_RUN     = 31;

  typedef struct packed {
    logic buserr;
    logic start;
    logic done;
    logic stopped;
    logic ras;
    logic eor;
    logic cmp;
  } sts_t;

  typedef struct packed {
    logic run;
    logic nofetch;
    logic stop_ie;
    logic eor_ie;
    logic eor_jmp;
    logic eor_stop;
    logic ras_ie;
  } ctl_t;

  typedef struct packed {
    logic stop;
    logic eor;
    logic ras;
    logic start;
    logic done;
  } cls_t;

  typedef struct packed {
    logic buserr;
    logic start;
    logic done;
    logic stop;
    logic ras;
    logic eor;
  } evt_t;

  localparam sts_t STS_RST = '{buserr: 1'b0, start: 1'b0, done: 1'b0, stopped: 1'b1,
                               ras: 1'b0, eor: 1'b0, cmp: 1'b0};
  localparam ctl_t CTL_RST = '0;
endpackage

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              req_i,
  input  evt_t              evt_i,
  output logic [WORD_W-1:0] csr_o,
  output ctl_t              ctl_o,
  output cls_t              cls_o,
  output logic              start_o,
  output logic              fetch_o
);
  sts_t sts_q, sts_d;
  ctl_t ctl_q, ctl_d;
  logic start_q, fetch_q;
  logic unused_wdata;

  assign unused_wdata = ^{wdata_i[21:11], wdata_i[8:5]};

  always_comb begin
    sts_d = sts_q;
    ctl_d = ctl_q;
    if (wr_i) begin
      if (wdata_i[B_BUSERR]) sts_d.buserr = 1'b0;
      if (wdata_i[B_START])  sts_d.start  = 1'b0;
      if (wdata_i[B_END])    sts_d.done   = 1'b0;
      if (wdata_i[B_EOR])    sts_d.eor    = 1'b0;
      if (wdata_i[B_RUN])        sts_d.stopped = 1'b0;
      else if (!wdata_i[B_MRUN]) sts_d.stopped = 1'b1;
      if (wdata_i[B_CMPSET])      sts_d.cmp = 1'b1;
      else if (wdata_i[B_CMPCLR]) sts_d.cmp = 1'b0;
      ctl_d.run      = wdata_i[B_RUN];
      ctl_d.nofetch  = wdata_i[B_NOFETCH];
      ctl_d.stop_ie  = wdata_i[B_STOPIE];
      ctl_d.eor_ie   = wdata_i[B_EORIE];
      ctl_d.eor_jmp  = wdata_i[B_EORJMP];
      ctl_d.eor_stop = wdata_i[B_EORSTOP];
      ctl_d.ras_ie   = wdata_i[B_RASIE];
    end
    // engine events take priority over software clears
    sts_d.buserr  = sts_d.buserr  | evt_i.buserr;
    sts_d.start   = sts_d.start   | evt_i.start;
    sts_d.done    = sts_d.done    | evt_i.done;
    sts_d.stopped = sts_d.stopped | evt_i.stop;
    sts_d.ras     = sts_d.ras     | evt_i.ras;
    sts_d.eor     = sts_d.eor     | evt_i.eor;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= STS_RST;
      ctl_q   <= CTL_RST;
      start_q <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      sts_q   <= sts_d;
      ctl_q   <= ctl_d;
      start_q <= wr_i & wdata_i[B_RUN];
      fetch_q <= wr_i & wdata_i[B_RUN] & ~wdata_i[B_NOFETCH];
    end
  end

  always_comb begin
    csr_o            = '0;
    csr_o[B_BUSERR]  = sts_q.buserr;
    csr_o[B_START]   = sts_q.start;
    csr_o[B_END]     = sts_q.done;
    csr_o[B_STOP]    = sts_q.stopped;
    csr_o[B_RAS]     = sts_q.ras;
    csr_o[B_REQ]     = req_i;
    csr_o[B_EOR]     = sts_q.eor;
    csr_o[B_CMP]     = sts_q.cmp;
    csr_o[B_RASIE]   = ctl_q.ras_ie;
    csr_o[B_EORSTOP] = ctl_q.eor_stop;
    csr_o[B_EORJMP]  = ctl_q.eor_jmp;
    csr_o[B_EORIE]   = ctl_q.eor_ie;
    csr_o[B_STOPIE]  = ctl_q.stop_ie;
    csr_o[B_NOFETCH] = ctl_q.nofetch;
    csr_o[B_RUN]     = ctl_q.run;
  end

  assign cls_o.stop  = sts_q.stopped & ctl_q.stop_ie;
  assign cls_o.eor   = sts_q.eor & ctl_q.eor_ie;
  assign cls_o.ras   = sts_q.ras & ctl_q.ras_ie;
  assign cls_o.start = sts_q.start;
  assign cls_o.done  = sts_q.done;

  assign ctl_o   = ctl_q;
  assign start_o = start_q;
  assign fetch_o = fetch_q;
endmodule

// File: rtl/dma_csr_irq_agg.sv
module dma_csr_irq_agg
  import dma_csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  cls_t [NUM_CH-1:0] cls_i,
  output logic [NUM_CH-1:0] pend_stop_o,
  output logic [NUM_CH-1:0] pend_eor_o,
  output logic [NUM_CH-1:0] pend_ras_o,
  output logic [NUM_CH-1:0] pend_start_o,
  output logic [NUM_CH-1:0] pend_end_o,
  output logic [NUM_CH-1:0] pend_sum_o,
  output logic              irq_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign pend_stop_o[g]  = cls_i[g].stop;
    assign pend_eor_o[g]   = cls_i[g].eor;
    assign pend_ras_o[g]   = cls_i[g].ras;
    assign pend_start_o[g] = cls_i[g].start;
    assign pend_end_o[g]   = cls_i[g].done;
    assign pend_sum_o[g]   = |cls_i[g];
  end

  assign irq_o = |pend_sum_o;
endmodule

// File: rtl/dma_csr_rd_mux.sv
module dma_csr_rd_mux
  import dma_csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CH_W   = 5
) (
  input  logic [NUM_CH-1:0][WORD_W-1:0] csr_i,
  input  logic [CH_W-1:0]               rd_ch_i,
  output logic [WORD_W-1:0]             rd_data_o
);
  localparam logic [CH_W:0] CH_LIM = (CH_W+1)'(NUM_CH);

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if ({1'b0, rd_ch_i} < CH_LIM && rd_ch_i == CH_W'(i)) rd_data_o = csr_i[i];
    end
  end
endmodule

// File: rtl/dma_csr_unit.sv
module dma_csr_unit
  import dma_csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [31:0]       wr_data_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [31:0]       rd_data_o,
  input  logic [NUM_CH-1:0] req_lvl_i,
  input  logic [NUM_CH-1:0] ev_buserr_i,
  input  logic [NUM_CH-1:0] ev_start_i,
  input  logic [NUM_CH-1:0] ev_end_i,
  input  logic [NUM_CH-1:0] ev_stop_i,
  input  logic [NUM_CH-1:0] ev_ras_i,
  input  logic [NUM_CH-1:0] ev_eor_i,
  output logic [NUM_CH-1:0] run_o,
  output logic [NUM_CH-1:0] nofetch_o,
  output logic [NUM_CH-1:0] eor_stop_o,
  output logic [NUM_CH-1:0] eor_jump_o,
  output logic [NUM_CH-1:0] chan_start_o,
  output logic [NUM_CH-1:0] desc_fetch_o,
  output logic [NUM_CH-1:0] pend_stop_o,
  output logic [NUM_CH-1:0] pend_eor_o,
  output logic [NUM_CH-1:0] pend_ras_o,
  output logic [NUM_CH-1:0] pend_start_o,
  output logic [NUM_CH-1:0] pend_end_o,
  output logic [NUM_CH-1:0] pend_sum_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0][WORD_W-1:0] csr;
  cls_t [NUM_CH-1:0]             cls;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic wr_sel;
    evt_t evt;
    ctl_t ctl;

    assign wr_sel     = wr_en_i && (wr_ch_i == CH_W'(g));
    assign evt.buserr = ev_buserr_i[g];
    assign evt.start  = ev_start_i[g];
    assign evt.done   = ev_end_i[g];
    assign evt.stop   = ev_stop_i[g];
    assign evt.ras    = ev_ras_i[g];
    assign evt.eor    = ev_eor_i[g];

    dma_csr_chan u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_sel),
      .wdata_i (wr_data_i),
      .req_i   (req_lvl_i[g]),
      .evt_i   (evt),
      .csr_o   (csr[g]),
      .ctl_o   (ctl),
      .cls_o   (cls[g]),
      .start_o (chan_start_o[g]),
      .fetch_o (desc_fetch_o[g])
    );

    assign run_o[g]      = ctl.run;
    assign nofetch_o[g]  = ctl.nofetch;
    assign eor_stop_o[g] = ctl.eor_stop;
    assign eor_jump_o[g] = ctl.eor_jmp;
  end

  dma_csr_irq_agg #(.NUM_CH(NUM_CH)) u_agg (
    .cls_i        (cls),
    .pend_stop_o  (pend_stop_o),
    .pend_eor_o   (pend_eor_o),
    .pend_ras_o   (pend_ras_o),
    .pend_start_o (pend_start_o),
    .pend_end_o   (pend_end_o),
    .pend_sum_o   (pend_sum_o),
    .irq_o        (irq_o)
  );

  dma_csr_rd_mux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rd (
    .csr_i     (csr),
    .rd_ch_i   (rd_ch_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/dma_csr_unit_chk.sv
module dma_csr_unit_chk #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CH_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [CH_W-1:0]   wr_ch_i,
  input logic [31:0]       wr_data_i,
  input logic [NUM_CH-1:0] ev_start_i,
  input logic [NUM_CH-1:0] ev_end_i,
  input logic [NUM_CH-1:0] run_o,
  input logic [NUM_CH-1:0] chan_start_o,
  input logic [NUM_CH-1:0] pend_stop_o,
  input logic [NUM_CH-1:0] pend_start_o,
  input logic [NUM_CH-1:0] pend_end_o,
  input logic [NUM_CH-1:0] pend_sum_o,
  input logic              irq_o
);
  logic wr_ok;
  assign wr_ok = wr_en_i && ({1'b0, wr_ch_i} < (CH_W+1)'(NUM_CH));

  assert_start_ev_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_start_i != '0) |=> ((pend_start_o & $past(ev_start_i)) == $past(ev_start_i)));

  assert_end_ev_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_end_i != '0) |=> ((pend_end_o & $past(ev_end_i)) == $past(ev_end_i)));

  assert_run_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && wr_data_i[31]) |=> chan_start_o[$past(wr_ch_i)]);

  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_start_o));

  assert_force_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && !wr_data_i[31] && !wr_data_i[22] && wr_data_i[29])
      |=> pend_stop_o[$past(wr_ch_i)]);

  assert_run_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(run_o));

  assert_irq_sum_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (pend_sum_o != '0));
endmodule

bind dma_csr_unit dma_csr_unit_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_ch_i      (wr_ch_i),
  .wr_data_i    (wr_data_i),
  .ev_start_i   (ev_start_i),
  .ev_end_i     (ev_end_i),
  .run_o        (run_o),
  .chan_start_o (chan_start_o),
  .pend_stop_o  (pend_stop_o),
  .pend_start_o (pend_start_o),
  .pend_end_o   (pend_end_o),
  .pend_sum_o   (pend_sum_o),
  .irq_o        (irq_o)
);

// File: tb/dma_csr_unit_bench.sv
module dma_csr_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [CW-1:0] wr_ch = '0, rd_ch = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NCH-1:0] req = '0, e_bus = '0, e_st = '0, e_end = '0, e_stop = '0, e_ras = '0, e_eor = '0;
  logic [NCH-1:0] run, nofetch, eorstop, eorjmp, cstart, dfetch;
  logic [NCH-1:0] p_stop, p_eor, p_ras, p_start, p_end, p_sum;
  logic irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_w [NCH];
  logic [NCH-1:0] exp_start, exp_fetch;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_csr_unit #(.NUM_CH(NCH)) u_dma_csr_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_data_i(wr_data),
    .rd_ch_i(rd_ch), .rd_data_o(rd_data), .req_lvl_i(req),
    .ev_buserr_i(e_bus), .ev_start_i(e_st), .ev_end_i(e_end), .ev_stop_i(e_stop),
    .ev_ras_i(e_ras), .ev_eor_i(e_eor),
    .run_o(run), .nofetch_o(nofetch), .eor_stop_o(eorstop), .eor_jump_o(eorjmp),
    .chan_start_o(cstart), .desc_fetch_o(dfetch),
    .pend_stop_o(p_stop), .pend_eor_o(p_eor), .pend_ras_o(p_ras), .pend_start_o(p_start),
    .pend_end_o(p_end), .pend_sum_o(p_sum), .irq_o(irq)
  );

  function automatic logic [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic logic [31:0] model_wr(logic [31:0] o, logic [31:0] v);
    logic [31:0] n = o;
    n[0] &= ~v[0]; n[1] &= ~v[1]; n[2] &= ~v[2]; n[9] &= ~v[9];
    if (v[31]) n[3] = 1'b0; else if (!v[22]) n[3] = 1'b1;
    if (v[25]) n[10] = 1'b1; else if (v[24]) n[10] = 1'b0;
    n[31:26] = v[31:26];
    n[23] = v[23];
    return n;
  endfunction

  // ev bits: 0 buserr, 1 start, 2 end, 3 stop, 4 ras, 5 eor
  function automatic logic [31:0] model_ev(logic [31:0] o, logic [5:0] e);
    logic [31:0] n = o;
    n[0] |= e[0]; n[1] |= e[1]; n[2] |= e[2]; n[3] |= e[3]; n[4] |= e[4]; n[9] |= e[5];
    return n;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic w, logic [CW-1:0] ch, logic [31:0] v, logic [6*NCH-1:0] ev);
    wr_en = w; wr_ch = ch; wr_data = v;
    for (int c = 0; c < NCH; c++) begin
      e_bus[c] = ev[c*6+0]; e_st[c] = ev[c*6+1]; e_end[c] = ev[c*6+2];
      e_stop[c] = ev[c*6+3]; e_ras[c] = ev[c*6+4]; e_eor[c] = ev[c*6+5];
      if (w && ch == CW'(c)) exp_w[c] = model_wr(exp_w[c], v);
      exp_w[c] = model_ev(exp_w[c], ev[c*6+:6]);
    end
    exp_start = '0; exp_fetch = '0;
    if (w && v[31]) exp_start[ch] = 1'b1;
    if (w && v[31] && !v[30]) exp_fetch[ch] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; e_bus = '0; e_st = '0; e_end = '0; e_stop = '0; e_ras = '0; e_eor = '0;
  endtask

  task automatic check_all(string tag);
    logic [NCH-1:0] xs, xe, xr, xst, xen, xsum, xrun, xnf, xes, xej;
    for (int c = 0; c < NCH; c++) begin
      rd_ch = CW'(c);
      #1;
      chk({tag, " R7 read"}, rd_data, exp_w[c] | (32'(req[c]) << 8));
      xs[c]  = exp_w[c][3] & exp_w[c][29];
      xe[c]  = exp_w[c][9] & exp_w[c][28];
      xr[c]  = exp_w[c][4] & exp_w[c][23];
      xst[c] = exp_w[c][1];
      xen[c] = exp_w[c][2];
      xsum[c] = xs[c] | xe[c] | xr[c] | xst[c] | xen[c];
      xrun[c] = exp_w[c][31]; xnf[c] = exp_w[c][30];
      xes[c] = exp_w[c][26]; xej[c] = exp_w[c][27];
    end
    chk({tag, " R8 stop"},  32'(p_stop),  32'(xs));
    chk({tag, " R8 eor"},   32'(p_eor),   32'(xe));
    chk({tag, " R8 ras"},   32'(p_ras),   32'(xr));
    chk({tag, " R8 start"}, 32'(p_start), 32'(xst));
    chk({tag, " R8 end"},   32'(p_end),   32'(xen));
    chk({tag, " R9 sum"},   32'(p_sum),   32'(xsum));
    chk({tag, " R9 irq"},   32'(irq),     32'(xsum != '0));
    chk({tag, " R12 ctl"},  {16'd0, run, nofetch, eorstop, eorjmp}, {16'd0, xrun, xnf, xes, xej});
    chk({tag, " R4 pulse"}, {24'd0, cstart, dfetch}, {24'd0, exp_start, exp_fetch});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) exp_w[c] = 32'h8;
    exp_start = '0; exp_fetch = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    req = 4'b0101;
    check_all("R7 live req");
    req = 4'b0000;
    check_all("R7 req drop");

    step(1'b1, 2'd1, 32'h8000_0000, '0);
    check_all("R4 run with fetch");
    step(1'b1, 2'd2, 32'hC000_0000, '0);
    check_all("R4 run no fetch");

    step(1'b1, 2'd1, 32'h2000_0000, '0);
    check_all("R5 force stop");
    step(1'b1, 2'd2, 32'h2040_0000, '0);
    check_all("R5 mask-run keeps running state");

    step(1'b1, 2'd3, 32'h0300_0000, '0);
    check_all("R6 both set wins");
    step(1'b1, 2'd3, 32'h0100_0000, '0);
    check_all("R6 clear");
    step(1'b1, 2'd3, 32'h0200_0000, '0);
    check_all("R6 set");

    step(1'b0, 2'd0, '0, 24'h00_0026);
    check_all("R11 events ch0");
    step(1'b1, 2'd0, 32'h1000_0207, 24'h00_0002);
    check_all("R10 event beats clear");
    step(1'b1, 2'd0, 32'h0080_0000, 24'h00_0010);
    check_all("R2 ras survives, R8 ras enabled");
    step(1'b1, 2'd0, 32'h0040_0010, '0);
    check_all("R2 ras not w1c, R3 bit22 not stored");

    for (int it = 0; it < 3000; it++) begin
      logic [31:0] v, a, b;
      v = rnd();
      a = rnd();
      b = rnd() & rnd();
      req = a[NCH-1:0];
      step(a[8], a[5:4], v, 24'(b & a & 32'h00EF_BFFF));
      check_all("sweep R2 R3 R8 R9 R10 R11 R12");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule